// File: doc/BRIEF.md
# Register Rename Stage with Zeroing Idiom Elimination

This block is the rename stage of a small out-of-order integer core with 16 architectural 64-bit registers. Each cycle it can take one decoded micro-op, which carries an operation class, two source register numbers, a destination number, a destination-present bit and an operand-size bit. It reads the current physical tag of each source, takes a fresh physical tag for the destination from a free list, and records the op in a 16-entry reorder buffer. It drives the renamed op to the scheduler one cycle later, together with a bit that says whether the op needs an execution unit.

An exclusive-OR or a subtract whose two sources name the same register always yields zero, whatever the old value was. The stage spots these ops at rename and binds the destination to physical tag 0, a register that always reads zero. Such an op reads no source, takes no tag from the free list and never goes to an execution unit. It reports a fixed flag result, and it is complete as soon as it is written into the reorder buffer. It still keeps its reorder slot until every older op has retired. The operand-size bit does not change this: a 32-bit write clears the upper half as well, so a 32-bit self-XOR zeroes the whole register. A move of immediate zero is not treated as an idiom.

Ops retire in order, one per cycle. When an op retires, the physical tag that its destination held before is returned to the free list. Tag 0 is never returned, because it is never on the free list.

Top module: `rn_stage`

## Requirements
- R1: An op with class XOR (1) or SUB (2), with the destination bit set and `in_src_a == in_src_b`, is an idiom. Its output shows `out_pdst_vld=1`, `out_pdst=0` and `out_exec=0`, and it takes no tag from the free list.
- R2: The size bit `in_is32` has no effect on idiom detection. A 32-bit self-XOR or self-SUB is a full idiom. The bit is passed through to `out_is32`.
- R3: An idiom shows `out_srca_vld=0` and `out_srcb_vld=0`, so it has no read dependency. Ops of class ALU (0), XOR or SUB that are not idioms show both bits as 1. MOVI (3) shows both bits as 0.
- R4: An idiom shows `out_flags_fix=1` and `out_flags=6'b001010`. The bit order is [5] carry, [4] overflow, [3] zero, [2] sign, [1] parity, [0] auxiliary carry. Every other op shows `out_flags_fix=0`.
- R5: A MOVI op (class 3) is never an idiom. With a destination, it gets a nonzero tag from the free list and `out_exec=1`.
- R6: After reset, every architectural register maps to tag 0 and the free list holds tags 1 to 31 in that order. A non-idiom op with a destination takes the tag at the head of the free list. Source tags are read from the map before this op's own update.
- R7: Every accepted op takes the reorder slot `out_rob`. Slots are handed out in order, modulo 16, starting at 0 after reset. An idiom is complete on entry. Any other op is complete when `wb_valid` names its slot. `cmt_valid` is 1 exactly when the oldest entry is complete, and `cmt_arch` and `cmt_ptag` then show its destination and its new tag.
- R8: When an op with a destination retires, the tag its destination held before it is appended to the tail of the free list, unless that tag is 0.
- R9: When the free list is empty, a non-idiom op with a destination is held (`in_ready=0`). An idiom, and a non-idiom op without a destination, are still accepted.
- R10: When the reorder buffer holds 16 entries, `in_ready=0` for every op.
- R11: After reset, `in_ready=1`, `out_valid=0` and `cmt_valid=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded op present |
| in_opc | input | 2 | Op class: 0 ALU, 1 XOR, 2 SUB, 3 MOVI |
| in_src_a | input | 4 | First source register |
| in_src_b | input | 4 | Second source register |
| in_dst | input | 4 | Destination register |
| in_is32 | input | 1 | 32-bit operand size |
| in_has_dst | input | 1 | Op writes a destination |
| in_ready | output | 1 | Op accepted this cycle if valid |
| wb_valid | input | 1 | Execution completion strobe |
| wb_rob | input | 4 | Reorder slot that completed |
| out_valid | output | 1 | Renamed op present |
| out_rob | output | 4 | Reorder slot of the op |
| out_ptag_a | output | 5 | Physical tag of the first source |
| out_ptag_b | output | 5 | Physical tag of the second source |
| out_srca_vld | output | 1 | First source is read |
| out_srcb_vld | output | 1 | Second source is read |
| out_pdst | output | 5 | Destination physical tag |
| out_pdst_vld | output | 1 | Destination present |
| out_exec | output | 1 | Op needs an execution unit |
| out_is32 | output | 1 | Size bit passed through |
| out_flags_fix | output | 1 | Flags are fixed at rename |
| out_flags | output | 6 | Fixed flag value |
| cmt_valid | output | 1 | Oldest op retires this cycle |
| cmt_arch | output | 4 | Destination register of the retiring op |
| cmt_ptag | output | 5 | New tag of the retiring op |

## Verification
The free list can be popped by rename and pushed by retirement in the same cycle. The most delicate case is an empty list at the moment a retirement frees a tag. The bench builds this case: it maps all 16 registers, then holds 15 ops with destinations open so that the list runs dry. It checks that a normal op is held while an idiom still gets through and fills the last reorder slot. It then sends completions, so that retirements and renames overlap, and every tag handed out afterwards is compared against an in-order model of the map, the list and the reorder buffer.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    OPC_ALU  = 2'd0,
    OPC_XOR  = 2'd1,
    OPC_SUB  = 2'd2,
    OPC_MOVI = 2'd3
  } opc_e;

  // carry, overflow, zero, sign, parity, aux-carry
  localparam logic [5:0] ZERO_FLAGS = 6'b001010;
endpackage

// File: rtl/rn_idiom_detect.sv
module rn_idiom_detect #(
  parameter int AW = 4
) (
  input  logic [1:0]    opc,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic          has_dst,
  output logic          is_idiom,
  output logic          rd_a,
  output logic          rd_b
);
  import rn_pkg::*;

  logic self_op;

  always_comb begin
    self_op  = (opc == OPC_XOR) || (opc == OPC_SUB);
    is_idiom = self_op && has_dst && (src_a == src_b);
    rd_a     = !is_idiom && (opc != OPC_MOVI);
    rd_b     = !is_idiom && (opc != OPC_MOVI);
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter  int NUM_PHYS = 32,
  localparam int PW       = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_tag,
  output logic [PW-1:0] head_tag,
  output logic          empty
);
  logic [PW-1:0] slot_q [NUM_PHYS];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [PW:0]   cnt_q, cnt_d;

  always_comb begin
    rd_d  = pop  ? rd_q + PW'(1) : rd_q;
    wr_d  = push ? wr_q + PW'(1) : wr_q;
    cnt_d = cnt_q + (PW+1)'(push) - (PW+1)'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= PW'(NUM_PHYS - 1);
      cnt_q <= (PW+1)'(NUM_PHYS - 1);
      for (int i = 0; i < NUM_PHYS; i++)
        slot_q[i] <= (i < NUM_PHYS - 1) ? PW'(i + 1) : '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
      if (push) slot_q[wr_q] <= push_tag;
    end
  end

  assign head_tag = slot_q[rd_q];
  assign empty    = (cnt_q == '0);
endmodule

// File: rtl/rn_rob.sv
module rn_rob #(
  parameter  int DEPTH = 16,
  parameter  int AW    = 4,
  parameter  int PW    = 5,
  localparam int RW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic [AW-1:0] alloc_arch,
  input  logic [PW-1:0] alloc_new,
  input  logic [PW-1:0] alloc_old,
  input  logic          alloc_hasd,
  input  logic          alloc_done,
  input  logic          wb_valid,
  input  logic [RW-1:0] wb_idx,
  output logic [RW-1:0] tail_idx,
  output logic          full,
  output logic          cmt_valid,
  output logic [AW-1:0] cmt_arch,
  output logic [PW-1:0] cmt_new,
  output logic [PW-1:0] cmt_old,
  output logic          cmt_hasd
);
  logic [AW-1:0] arch_q [DEPTH];
  logic [PW-1:0] new_q  [DEPTH];
  logic [PW-1:0] old_q  [DEPTH];
  logic          hasd_q [DEPTH];
  logic [DEPTH-1:0] done_q;
  logic [RW-1:0] head_q, head_d, tail_q, tail_d;
  logic [RW:0]   cnt_q, cnt_d;
  logic          retire;

  always_comb begin
    retire = (cnt_q != '0) && done_q[head_q];
    head_d = retire ? head_q + RW'(1) : head_q;
    tail_d = alloc  ? tail_q + RW'(1) : tail_q;
    cnt_d  = cnt_q + (RW+1)'(alloc) - (RW+1)'(retire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      done_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      if (wb_valid) done_q[wb_idx] <= 1'b1;
      if (alloc)    done_q[tail_q] <= alloc_done;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      arch_q[tail_q] <= alloc_arch;
      new_q[tail_q]  <= alloc_new;
      old_q[tail_q]  <= alloc_old;
      hasd_q[tail_q] <= alloc_hasd;
    end
  end

  assign tail_idx  = tail_q;
  assign full      = (cnt_q == (RW+1)'(DEPTH));
  assign cmt_valid = retire;
  assign cmt_arch  = arch_q[head_q];
  assign cmt_new   = new_q[head_q];
  assign cmt_old   = old_q[head_q];
  assign cmt_hasd  = hasd_q[head_q];
endmodule

// File: rtl/rn_stage.sv
module rn_stage #(
  parameter  int NUM_ARCH  = 16,
  parameter  int NUM_PHYS  = 32,
  parameter  int ROB_DEPTH = 16,
  localparam int AW        = $clog2(NUM_ARCH),
  localparam int PW        = $clog2(NUM_PHYS),
  localparam int RW        = $clog2(ROB_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_opc,
  input  logic [AW-1:0] in_src_a,
  input  logic [AW-1:0] in_src_b,
  input  logic [AW-1:0] in_dst,
  input  logic          in_is32,
  input  logic          in_has_dst,
  output logic          in_ready,
  input  logic          wb_valid,
  input  logic [RW-1:0] wb_rob,
  output logic          out_valid,
  output logic [RW-1:0] out_rob,
  output logic [PW-1:0] out_ptag_a,
  output logic [PW-1:0] out_ptag_b,
  output logic          out_srca_vld,
  output logic          out_srcb_vld,
  output logic [PW-1:0] out_pdst,
  output logic          out_pdst_vld,
  output logic          out_exec,
  output logic          out_is32,
  output logic          out_flags_fix,
  output logic [5:0]    out_flags,
  output logic          cmt_valid,
  output logic [AW-1:0] cmt_arch,
  output logic [PW-1:0] cmt_ptag
);
  import rn_pkg::*;

  logic [PW-1:0] map_q [NUM_ARCH];
  logic          is_idiom, rd_a, rd_b;
  logic          fl_empty, fl_pop, fl_push;
  logic [PW-1:0] fl_head, new_tag;
  logic          rob_full, accept;
  logic [RW-1:0] rob_tail;
  logic [PW-1:0] c_old;
  logic          c_hasd;

  rn_idiom_detect #(.AW(AW)) u_det (
    .opc(in_opc), .src_a(in_src_a), .src_b(in_src_b), .has_dst(in_has_dst),
    .is_idiom(is_idiom), .rd_a(rd_a), .rd_b(rd_b)
  );

  always_comb begin
    new_tag  = '0;
    if (!is_idiom && in_has_dst) new_tag = fl_head;
    in_ready = !rob_full && (is_idiom || !in_has_dst || !fl_empty);
    accept   = in_valid && in_ready;
    fl_pop   = accept && !is_idiom && in_has_dst;
    fl_push  = cmt_valid && c_hasd && (c_old != '0);
  end

  rn_free_list #(.NUM_PHYS(NUM_PHYS)) u_fl (
    .clk(clk), .rst_n(rst_n), .pop(fl_pop), .push(fl_push), .push_tag(c_old),
    .head_tag(fl_head), .empty(fl_empty)
  );

  rn_rob #(.DEPTH(ROB_DEPTH), .AW(AW), .PW(PW)) u_rob (
    .clk(clk), .rst_n(rst_n), .alloc(accept), .alloc_arch(in_dst),
    .alloc_new(new_tag), .alloc_old(in_has_dst ? map_q[in_dst] : '0),
    .alloc_hasd(in_has_dst), .alloc_done(is_idiom),
    .wb_valid(wb_valid), .wb_idx(wb_rob),
    .tail_idx(rob_tail), .full(rob_full),
    .cmt_valid(cmt_valid), .cmt_arch(cmt_arch), .cmt_new(cmt_ptag),
    .cmt_old(c_old), .cmt_hasd(c_hasd)
  );

  // map table: every register starts bound to the zero tag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= '0;
    end else if (accept && in_has_dst) begin
      map_q[in_dst] <= new_tag;
    end
  end

  // output stage
  logic [PW-1:0] ptag_a_d, ptag_b_d;
  logic          exec_d, fix_d;
  logic [5:0]    flags_d;

  always_comb begin
    ptag_a_d = rd_a ? map_q[in_src_a] : '0;
    ptag_b_d = rd_b ? map_q[in_src_b] : '0;
    exec_d   = !is_idiom;
    fix_d    = is_idiom;
    flags_d  = is_idiom ? ZERO_FLAGS : 6'b000000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_rob       <= rob_tail;
      out_ptag_a    <= ptag_a_d;
      out_ptag_b    <= ptag_b_d;
      out_srca_vld  <= rd_a;
      out_srcb_vld  <= rd_b;
      out_pdst      <= new_tag;
      out_pdst_vld  <= in_has_dst;
      out_exec      <= exec_d;
      out_is32      <= in_is32;
      out_flags_fix <= fix_d;
      out_flags     <= flags_d;
    end
  end
endmodule

// File: rtl/rn_stage_chk.sv
module rn_stage_chk #(
  parameter int AW = 4,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    in_opc,
  input logic [AW-1:0] in_src_a,
  input logic [AW-1:0] in_src_b,
  input logic          in_has_dst,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_srca_vld,
  input logic          out_srcb_vld,
  input logic [PW-1:0] out_pdst,
  input logic          out_pdst_vld,
  input logic          out_exec,
  input logic          out_flags_fix,
  input logic [5:0]    out_flags
);
  import rn_pkg::*;

  logic take_idiom, take_movi;
  assign take_idiom = in_valid && in_ready && in_has_dst && in_src_a == in_src_b &&
                      (in_opc == OPC_XOR || in_opc == OPC_SUB);
  assign take_movi  = in_valid && in_ready && in_has_dst && in_opc == OPC_MOVI;

  AST_IDIOM_ZERO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    take_idiom |=> (out_valid && out_pdst_vld && out_pdst == '0 && !out_exec)); // R1

  AST_ZERO_TAG_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pdst_vld && out_pdst == '0) |-> !out_exec); // R1

  AST_IDIOM_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    take_idiom |=> (!out_srca_vld && !out_srcb_vld)); // R3

  AST_IDIOM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags_fix) |-> (out_flags == 6'b001010)); // R4

  AST_MOVI_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    take_movi |=> (out_exec && out_pdst != '0 && !out_flags_fix)); // R5
endmodule

bind rn_stage rn_stage_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opc(in_opc),
  .in_src_a(in_src_a), .in_src_b(in_src_b), .in_has_dst(in_has_dst),
  .in_ready(in_ready), .out_valid(out_valid), .out_srca_vld(out_srca_vld),
  .out_srcb_vld(out_srcb_vld), .out_pdst(out_pdst), .out_pdst_vld(out_pdst_vld),
  .out_exec(out_exec), .out_flags_fix(out_flags_fix), .out_flags(out_flags)
);

// File: tb/sim_rn_stage.sv
`timescale 1ns/100ps
module sim_rn_stage;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_is32, in_has_dst, wb_valid;
  logic [1:0] in_opc;
  logic [3:0] in_src_a, in_src_b, in_dst, wb_rob;
  logic in_ready, out_valid, out_srca_vld, out_srcb_vld, out_pdst_vld, out_exec;
  logic out_is32, out_flags_fix, cmt_valid;
  logic [3:0] out_rob, cmt_arch;
  logic [4:0] out_ptag_a, out_ptag_b, out_pdst, cmt_ptag;
  logic [5:0] out_flags;

  always #2.5 clk = ~clk;

  rn_stage u0 (.*);

  int total = 0, bad = 0;
  // reference model
  int bmap [16];
  int bfl [$];
  int r_arch [16], r_new [16], r_old [16];
  bit r_hasd [16], r_done [16];
  int r_head, r_tail, r_cnt;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin bmap[i] = 0; r_done[i] = 0; end
    bfl.delete();
    for (int i = 1; i < 32; i++) bfl.push_back(i);
    r_head = 0; r_tail = 0; r_cnt = 0;
  endtask

  task automatic cyc(input bit v, input int opc, input int a, input int b, input int d,
                     input bit w32, input bit hasd, input bit wv, input int widx);
    bit idi, rdy, acc, cm, rda;
    int ea, eb, ep, et, h;
    in_valid = v; in_opc = 2'(opc); in_src_a = 4'(a); in_src_b = 4'(b);
    in_dst = 4'(d); in_is32 = w32; in_has_dst = hasd; wb_valid = wv; wb_rob = 4'(widx);
    idi = (opc == 1 || opc == 2) && a == b && hasd;
    rdy = r_cnt < 16 && (idi || !hasd || bfl.size() > 0);
    cm  = r_cnt > 0 && r_done[r_head];
    rda = !idi && opc != 3;
    #1;
    chk(in_ready == rdy, "R9 R10", "in_ready", int'(in_ready), int'(rdy));
    chk(cmt_valid == cm, "R7", "cmt_valid", int'(cmt_valid), int'(cm));
    if (cm) begin
      chk(cmt_arch == 4'(r_arch[r_head]), "R7", "cmt_arch", int'(cmt_arch), r_arch[r_head]);
      chk(cmt_ptag == 5'(r_new[r_head]), "R7", "cmt_ptag", int'(cmt_ptag), r_new[r_head]);
    end
    acc = v && rdy;
    ea = bmap[a]; eb = bmap[b]; et = r_tail; ep = 0;
    @(posedge clk);
    if (acc) begin
      ep = (!idi && hasd) ? bfl.pop_front() : 0;
      r_arch[et] = d; r_new[et] = ep; r_hasd[et] = hasd;
      r_old[et] = hasd ? bmap[d] : 0;
      if (hasd) bmap[d] = ep;
      r_done[et] = idi;
      r_tail = (r_tail + 1) % 16; r_cnt++;
    end
    if (cm) begin
      h = r_head;
      if (r_hasd[h] && r_old[h] != 0) bfl.push_back(r_old[h]);
      r_head = (r_head + 1) % 16; r_cnt--;
    end
    if (wv) r_done[widx] = 1;
    @(negedge clk);
    in_valid = 0; wb_valid = 0;
    chk(out_valid == acc, "R7", "out_valid", int'(out_valid), int'(acc));
    if (acc) begin
      chk(out_rob == 4'(et), "R7", "out_rob", int'(out_rob), et);
      chk(out_pdst == 5'(ep), "R1 R6 R8", "out_pdst", int'(out_pdst), ep);
      chk(out_pdst_vld == hasd, "R6", "out_pdst_vld", int'(out_pdst_vld), int'(hasd));
      chk(out_exec == !idi, "R1 R5", "out_exec", int'(out_exec), int'(!idi));
      chk(out_srca_vld == rda && out_srcb_vld == rda, "R3", "src_vld",
          int'({out_srca_vld, out_srcb_vld}), rda ? 3 : 0);
      if (rda) begin
        chk(out_ptag_a == 5'(ea), "R6", "ptag_a", int'(out_ptag_a), ea);
        chk(out_ptag_b == 5'(eb), "R6", "ptag_b", int'(out_ptag_b), eb);
      end
      chk(out_flags_fix == idi, "R4", "flags_fix", int'(out_flags_fix), int'(idi));
      if (idi) chk(out_flags == 6'b001010, "R4", "flags", int'(out_flags), 10);
      chk(out_is32 == w32, "R2", "is32", int'(out_is32), int'(w32));
    end
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

  task automatic drain();
    int k, idx;
    while (r_cnt > 0) begin
      idx = -1;
      for (int j = 0; j < r_cnt; j++) begin
        k = (r_head + j) % 16;
        if (!r_done[k] && idx < 0) idx = k;
      end
      if (idx >= 0) cyc(0, 0, 0, 0, 0, 0, 0, 1, idx);
      else idle();
    end
    idle();
  endtask

  task automatic t_reset();
    rst_n = 0; in_valid = 0; wb_valid = 0; in_opc = 0; in_src_a = 0; in_src_b = 0;
    in_dst = 0; in_is32 = 0; in_has_dst = 0; wb_rob = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(in_ready == 1'b1, "R11", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
    chk(cmt_valid == 1'b0, "R11", "cmt_valid after reset", int'(cmt_valid), 0);
    @(negedge clk);
    cyc(1, 0, 5, 9, 3, 0, 1, 0, 0);   // R6: reads tag 0, gets tag 1
    chk(out_ptag_a == 5'd0 && out_pdst == 5'd1, "R6", "first rename", int'(out_pdst), 1);
    drain();
  endtask

  task automatic t_idioms();
    cyc(1, 1, 3, 3, 3, 0, 1, 0, 0);   // R1 64-bit self-XOR
    chk(out_pdst == 5'd0 && !out_exec, "R1", "xor idiom tag", int'(out_pdst), 0);
    cyc(1, 2, 7, 7, 7, 1, 1, 0, 0);   // R2 32-bit self-SUB
    chk(out_pdst == 5'd0 && out_is32, "R2", "sub32 idiom", int'(out_pdst), 0);
    cyc(1, 1, 4, 4, 6, 1, 1, 0, 0);   // R2 32-bit self-XOR into other reg
    cyc(1, 1, 4, 5, 6, 1, 1, 0, 0);   // not idiom
    cyc(1, 2, 2, 2, 0, 0, 0, 0, 0);   // no destination: not idiom
    cyc(1, 0, 3, 7, 8, 0, 1, 0, 0);   // reads zero tags after idioms
    chk(out_ptag_a == 5'd0 && out_ptag_b == 5'd0, "R6", "zero readback", int'(out_ptag_a), 0);
    drain();
  endtask

  task automatic t_movi();
    cyc(1, 3, 0, 0, 4, 0, 1, 0, 0);
    chk(out_exec && out_pdst != 5'd0 && !out_flags_fix, "R5", "movi zero not idiom",
        int'(out_pdst), bfl.size() >= 0 ? int'(out_pdst) : 0);
    drain();
  endtask

  task automatic t_order();
    cyc(1, 0, 1, 2, 1, 0, 1, 0, 0);   // pending ALU
    cyc(1, 1, 9, 9, 9, 0, 1, 0, 0);   // idiom behind it
    idle();
    chk(cmt_valid == 1'b0, "R7", "idiom waits for older op", int'(cmt_valid), 0);
    drain();
  endtask

  task automatic t_empty();
    for (int r = 0; r < 16; r++) cyc(1, 0, r, r, r, 0, 1, 0, 0);
    drain();
    for (int i = 0; i < 40 && bfl.size() > 0; i++) cyc(1, 0, 1, 2, i % 16, 0, 1, 0, 0);
    chk(bfl.size() == 0, "R9", "model list drained", bfl.size(), 0);
    cyc(1, 0, 1, 2, 5, 0, 1, 0, 0);   // held
    chk(in_ready == 1'b0 || r_cnt == 16, "R9", "normal op held", int'(in_ready), 0);
    if (r_cnt < 16) cyc(1, 2, 6, 6, 6, 0, 1, 0, 0);   // idiom accepted
    cyc(1, 1, 8, 8, 8, 0, 1, 0, 0);   // ROB full now
    chk(r_cnt == 16, "R10", "rob full", r_cnt, 16);
    drain();
  endtask

  task automatic t_random();
    int opc, a, b, d, k, idx;
    bit wv;
    for (int i = 0; i < 600; i++) begin
      opc = $urandom_range(0, 3);
      a = $urandom_range(0, 15);
      b = ($urandom_range(0, 9) < 3) ? a : $urandom_range(0, 15);
      d = $urandom_range(0, 15);
      wv = 0; idx = 0;
      if (r_cnt > 0) begin
        k = (r_head + $urandom_range(0, r_cnt - 1)) % 16;
        if (!r_done[k] && $urandom_range(0, 3) != 0) begin wv = 1; idx = k; end
      end
      cyc($urandom_range(0, 4) != 0, opc, a, b, d, $urandom_range(0, 1),
          $urandom_range(0, 7) != 0, wv, idx);
    end
    drain();
  endtask

  task automatic t_readback();
    for (int r = 0; r < 16; r++) cyc(1, 0, r, r, 0, 0, 0, 0, 0);   // R6 R8
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_idioms();
    t_movi();
    t_order();
    t_empty();
    t_random();
    t_readback();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule